// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block manages the start and stop conditions of an I2C data/clock line pair. A byte-wide control/status register lets software issue a one-shot "start" command, which pulls the serial data output latch low. It also lets software issue a one-shot "stop" command, which releases that latch high. Each command bit clears itself once it has acted. The same register has two read-only flags. They report start and stop conditions that the block has observed on the bus.

The clock and data lines enter through a two-flop synchronizer. A start is recognised when data falls while the clock has been high for two sampled cycles. A stop is recognised when data rises under the same clock condition. Each flag is cleared by its own set of events: a transfer-start strobe, an address-mismatch strobe, a later stop, or the interface being disabled. When a set event and a clear event land in the same cycle, the clear takes effect. Bit shifting, clock generation, acknowledge detection and address comparison belong to neighbouring logic.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: A register write with bit 0 (stop command) = 1 while `ifEnable` is high makes bit 0 read 1 after the write edge. At the following edge `sdaLatch` becomes 1 and bit 0 returns to 0.
- R2: A register write with bit 1 (start command) = 1 while `ifEnable` is high makes bit 1 read 1 after the write edge. At the following edge `sdaLatch` becomes 0 and bit 1 returns to 0. If both command bits are pending, the start command decides the latch value (0).
- R3: While `ifEnable` is low, bits 1:0 read 0, a write of 1 to them is discarded, and `sdaLatch` keeps its value.
- R4: After the two-flop synchronizer, data falling while the clock is high in both sampled cycles sets bit 3 (start seen). Data rising under the same clock condition sets bit 2 (stop seen). A flag becomes visible on the third rising clock edge after the line change.
- R5: Bit 2 (stop seen) is cleared by `xferStart`, by `addrMismatch`, and by `ifEnable` low. `addrMismatch` leaves bit 3 unchanged.
- R6: Bit 3 (start seen) is cleared by `xferStart`, by a detected stop condition, and by `ifEnable` low.
- R7: When a flag's set event and one of its clear events fall in the same cycle, the flag reads 0 afterwards.
- R8: After reset the register reads 00h and `sdaLatch` is 1. Bits 7, 5 and 4 are plain read/write storage. Writes to bits 6, 3 and 2 are ignored, and bit 6 reads 0.
- R9: Data changes while the clock is low set neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line, asynchronous |
| ifEnable | input | 1 | Serial interface enable |
| xferStart | input | 1 | One-cycle transfer-start strobe |
| addrMismatch | input | 1 | One-cycle strobe: received address did not match |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| sdaLatch | output | 1 | Serial data output latch |
| regValue | output | 8 | Register read value |

## Verification
A flag can have a set event and a clear event in the same clock cycle. The detection strobe for a bus condition and a transfer-start or address-mismatch strobe can coincide. The bench provokes this by moving the data line and then raising the strobe exactly during the cycle in which the synchronized edge is recognised. It then requires the flag to read 0 at that point and one cycle later. Separate runs without the strobe show that the same line change does set the flag. Together these show that the check exercises the collision and not an absence of detection.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int REG_W          = 8;
  localparam int BIT_STOP_CMD   = 0;
  localparam int BIT_START_CMD  = 1;
  localparam int BIT_STOP_SEEN  = 2;
  localparam int BIT_START_SEEN = 3;
  localparam int BIT_ACK_FORCE  = 4;
  localparam int BIT_ACK_AUTO   = 5;
  localparam int BIT_ACK_SEEN   = 6;
  localparam int BIT_BUS_OE     = 7;

  // strobes from the sequencing logic to the register datapath
  typedef struct packed {
    logic setStartSeen;
    logic clrStartSeen;
    logic setStopSeen;
    logic clrStopSeen;
    logic loadStopCmd;
    logic loadStartCmd;
    logic killCmd;
    logic wrCfg;
  } condStrobes_t;
endpackage

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         ifEnable,
  input  logic         xferStart,
  input  logic         addrMismatch,
  input  logic         regWrEn,
  input  logic [1:0]   cmdWr,
  output condStrobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclPrev;
  logic sdaPrev;
  logic startEdge;
  logic stopEdge;

  // synchronizer chains, idle-high reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      sclPrev    <= sclSync[LAST];
      sdaPrev    <= sdaSync[LAST];
    end
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSync[i] <= 1'b1;
          sdaSync[i] <= 1'b1;
        end else begin
          sclSync[i] <= sclSync[i-1];
          sdaSync[i] <= sdaSync[i-1];
        end
      end
    end
  endgenerate

  // a condition needs the clock high in both sampled cycles
  always_comb begin
    startEdge = sclSync[LAST] && sclPrev &&  sdaPrev && !sdaSync[LAST];
    stopEdge  = sclSync[LAST] && sclPrev && !sdaPrev &&  sdaSync[LAST];
  end

  always_comb begin
    strobes              = '0;
    strobes.setStartSeen = startEdge;
    strobes.setStopSeen  = stopEdge;
    strobes.clrStartSeen = xferStart || stopEdge || !ifEnable;
    strobes.clrStopSeen  = xferStart || addrMismatch || !ifEnable;
    strobes.loadStopCmd  = regWrEn && ifEnable && cmdWr[0];
    strobes.loadStartCmd = regWrEn && ifEnable && cmdWr[1];
    strobes.killCmd      = !ifEnable;
    strobes.wrCfg        = regWrEn;
  end
endmodule

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  condStrobes_t     strobes,
  input  logic [2:0]       cfgWr,
  output logic             sdaLatch,
  output logic [REG_W-1:0] regValue
);
  logic stopCmd;
  logic startCmd;
  logic stopSeen;
  logic startSeen;
  logic [2:0] cfgBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopCmd  <= 1'b0;
      startCmd <= 1'b0;
      sdaLatch <= 1'b1;
    end else begin
      // a pending command acts once, then its bit drops
      stopCmd  <= strobes.loadStopCmd;
      startCmd <= strobes.loadStartCmd;
      if (!strobes.killCmd) begin
        if (startCmd)      sdaLatch <= 1'b0;
        else if (stopCmd)  sdaLatch <= 1'b1;
      end
    end
  end

  // clear outranks set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopSeen  <= 1'b0;
      startSeen <= 1'b0;
    end else begin
      if (strobes.clrStopSeen)       stopSeen  <= 1'b0;
      else if (strobes.setStopSeen)  stopSeen  <= 1'b1;
      if (strobes.clrStartSeen)      startSeen <= 1'b0;
      else if (strobes.setStartSeen) startSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cfgBits <= '0;
    else if (strobes.wrCfg) cfgBits <= cfgWr;
  end

  always_comb begin
    regValue                 = '0;
    regValue[BIT_STOP_CMD]   = stopCmd;
    regValue[BIT_START_CMD]  = startCmd;
    regValue[BIT_STOP_SEEN]  = stopSeen;
    regValue[BIT_START_SEEN] = startSeen;
    regValue[BIT_ACK_FORCE]  = cfgBits[0];
    regValue[BIT_ACK_AUTO]   = cfgBits[1];
    regValue[BIT_ACK_SEEN]   = 1'b0;
    regValue[BIT_BUS_OE]     = cfgBits[2];
  end
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       ifEnable,
  input  logic       xferStart,
  input  logic       addrMismatch,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic       sdaLatch,
  output logic [7:0] regValue
);
  condStrobes_t strobes;

  i2c_cond_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .ifEnable     (ifEnable),
    .xferStart    (xferStart),
    .addrMismatch (addrMismatch),
    .regWrEn      (regWrEn),
    .cmdWr        ({regWrData[BIT_START_CMD], regWrData[BIT_STOP_CMD]}),
    .strobes      (strobes)
  );

  i2c_cond_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWr    ({regWrData[BIT_BUS_OE], regWrData[BIT_ACK_AUTO], regWrData[BIT_ACK_FORCE]}),
    .sdaLatch (sdaLatch),
    .regValue (regValue)
  );
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ifEnable,
  input logic       xferStart,
  input logic       addrMismatch,
  input logic       sdaLatch,
  input logic [7:0] regValue
);
  AST_STOP_CMD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && regValue[0] && !regValue[1]) |=> sdaLatch); // R1
  AST_START_CMD_PULLS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && regValue[1]) |=> !sdaLatch); // R2
  AST_DISABLE_CLEARS_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> (regValue[1:0] == 2'b00)); // R3
  AST_DISABLE_HOLDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> $stable(sdaLatch)); // R3
  AST_MISMATCH_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    addrMismatch |=> !regValue[2]); // R5
  AST_DISABLE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> (regValue[3:2] == 2'b00)); // R6
  AST_XFER_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (regValue[3:2] == 2'b00)); // R7
endmodule

bind i2c_cond_ctrl i2c_cond_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ifEnable     (ifEnable),
  .xferStart    (xferStart),
  .addrMismatch (addrMismatch),
  .sdaLatch     (sdaLatch),
  .regValue     (regValue)
);

// File: tb/tb_i2c_cond_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_cond_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic ifEnable = 1'b0, xferStart = 1'b0, addrMismatch = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic sdaLatch;
  logic [7:0] regValue;
  int nChecks = 0;
  int nErrors = 0;
  bit expLatch;

  always #2 clk = ~clk;

  i2c_cond_ctrl dut (.*);

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic busSet(input logic s, input logic d);
    @(negedge clk); sclIn = s; sdaIn = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseXfer();
    @(negedge clk); xferStart = 1'b1;
    @(negedge clk); xferStart = 1'b0;
  endtask

  task automatic pulseMis();
    @(negedge clk); addrMismatch = 1'b1;
    @(negedge clk); addrMismatch = 1'b0;
  endtask

  task automatic pulseDisable();
    @(negedge clk); ifEnable = 1'b0;
    @(negedge clk); ifEnable = 1'b1;
  endtask

  task automatic makeStart();   // leaves scl=1, sda=0
    busSet(1'b0, 1'b1); busSet(1'b1, 1'b1); busSet(1'b1, 1'b0);
  endtask

  task automatic makeStop();    // leaves scl=1, sda=1
    busSet(1'b0, 1'b0); busSet(1'b1, 1'b0); busSet(1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regValue === 8'h00, "R8 reset value", regValue, 8'h00);
    check(sdaLatch === 1'b1, "R8 reset latch", {7'd0, sdaLatch}, 8'h01);
    expLatch = 1'b1;

    // sweep of every write value with the interface off and on
    for (int en = 0; en < 2; en++) begin
      ifEnable = en[0];
      for (int v = 0; v < 256; v++) begin
        logic [7:0] d;
        logic [7:0] expWr;
        d = v[7:0];
        expWr = (d & 8'hB0) | (en[0] ? (d & 8'h03) : 8'h00);
        writeReg(d);
        check((regValue & 8'hF0) === (expWr & 8'hF0), "R8 cfg bits and ro bit 6", regValue, expWr);
        check(regValue[1:0] === expWr[1:0], en[0] ? "R1 R2 cmd readback" : "R3 cmd write discarded",
              {6'd0, regValue[1:0]}, {6'd0, expWr[1:0]});
        check(regValue[3:2] === 2'b00, "R8 flag bits not writable", regValue, expWr);
        if (en[0] && d[1])      expLatch = 1'b0;
        else if (en[0] && d[0]) expLatch = 1'b1;
        @(negedge clk);
        check(regValue[1:0] === 2'b00, "R1 R2 cmd self clear", regValue, regValue & 8'hFC);
        check(sdaLatch === expLatch, d[1] ? "R2 start latch" : (d[0] ? "R1 stop latch" : "R3 latch hold"),
              {7'd0, sdaLatch}, {7'd0, expLatch});
      end
    end
    writeReg(8'h00);

    // detection and its clear events
    makeStart();
    check(regValue[3:2] === 2'b10, "R4 start detected", regValue, 8'h08);
    pulseMis();
    check(regValue[3] === 1'b1, "R5 mismatch keeps start flag", regValue, 8'h08);
    pulseXfer();
    check(regValue[3:2] === 2'b00, "R6 xferStart clears start", regValue, 8'h00);
    makeStart();
    makeStop();
    check(regValue[3:2] === 2'b01, "R6 stop clears start, R4 stop detected", regValue, 8'h04);
    pulseMis();
    check(regValue[2] === 1'b0, "R5 mismatch clears stop", regValue, 8'h00);
    makeStop();
    check(regValue[2] === 1'b1, "R4 stop detected again", regValue, 8'h04);
    pulseXfer();
    check(regValue[2] === 1'b0, "R5 xferStart clears stop", regValue, 8'h00);
    makeStop();
    pulseDisable();
    check(regValue[2] === 1'b0, "R5 disable clears stop", regValue, 8'h00);
    makeStart();
    pulseDisable();
    check(regValue[3] === 1'b0, "R6 disable clears start", regValue, 8'h00);

    // data toggles with the clock low
    busSet(1'b0, 1'b0); busSet(1'b0, 1'b1); busSet(1'b0, 1'b0); busSet(1'b0, 1'b1);
    check(regValue[3:2] === 2'b00, "R9 no condition with clock low", regValue, 8'h00);

    // collision: start recognised in the cycle xferStart is high
    busSet(1'b1, 1'b1);
    @(negedge clk); sdaIn = 1'b0;
    @(negedge clk);
    @(negedge clk); xferStart = 1'b1;
    @(negedge clk); xferStart = 1'b0;
    check(regValue[3] === 1'b0, "R7 clear beats start set", regValue, 8'h00);
    @(negedge clk);
    check(regValue[3] === 1'b0, "R7 start stays clear", regValue, 8'h00);
    // collision: stop recognised in the cycle addrMismatch is high
    busSet(1'b0, 1'b0); busSet(1'b1, 1'b0);
    @(negedge clk); sdaIn = 1'b1;
    @(negedge clk);
    @(negedge clk); addrMismatch = 1'b1;
    @(negedge clk); addrMismatch = 1'b0;
    check(regValue[2] === 1'b0, "R7 clear beats stop set", regValue, 8'h00);
    @(negedge clk);
    check(regValue[2] === 1'b0, "R7 stop stays clear", regValue, 8'h00);

    // both commands pending: start decides
    writeReg(8'h01);
    @(negedge clk);
    writeReg(8'h03);
    @(negedge clk);
    check(sdaLatch === 1'b0, "R2 start wins over stop", {7'd0, sdaLatch}, 8'h00);

    finishRun();
  end
endmodule